// File: doc/BRIEF.md
# Control Transfer Stage Tracker

This block follows the stage of a device-side control transfer on endpoint 0. It watches decoded bus events: setup completion together with the request's direction bit and length field, IN, OUT and PING tokens, received data packets with their data PID, and handshakes sent or received. From these it keeps a 3-bit stage code. It raises a status bit, with an enable-gated interrupt, each time the stage changes.

When the host breaks the expected token or data-PID order for a read, write or no-data request, the block enters a sequence-error stage. It then forces the endpoint-0 response control to STALL. The error code stays held until software clears the status bit. A SETUP that completes while the error is held is remembered, and its setup-end interrupt is raised only after the clear.

The block is placed next to the serial interface engine. Software reads `stage_o` after each interrupt and pulses `sts_clr_i` to acknowledge it.

Top module: `ctrl_stage_tracker`

## Requirements
- R1: A completed SETUP while no error is held moves the stage to 3'b001 if direction is device-to-host and the length is non-zero, to 3'b011 if direction is host-to-device and the length is non-zero, and to 3'b101 if the length is zero. This applies even in the middle of another transfer, and it clears STALL.
- R2: In stage 3'b001, an OUT or PING token before any host ACK has been seen gives stage 3'b110. After at least one host ACK, the same token gives stage 3'b010. IN tokens leave the stage unchanged.
- R3: In stage 3'b010, an IN token or a DATA0 packet gives 3'b110. A DATA1 packet of any length ends the transfer normally with stage 3'b000.
- R4: In stage 3'b011, a first data packet carrying DATA0 gives 3'b110, and an IN token before any device ACK gives 3'b110. After a device ACK, an IN token gives 3'b100. Further DATA1 packets, including packets beyond the requested length, raise no error.
- R5: In stages 3'b100 and 3'b101, an OUT or PING token gives 3'b110, and a host ACK ends the transfer with stage 3'b000.
- R6: `pid_ctl_o` reads 2'b10 (STALL) from the cycle a sequence error is taken until the next accepted SETUP. Otherwise it reads 2'b01.
- R7: Stage 3'b110 is held until `sts_clr_i` is pulsed. If no SETUP is pending, the stage then returns to 3'b000 and the status bit is not set again.
- R8: A SETUP during the held error leaves the stage at 3'b110 and does not set the status bit. On the clear, the stage goes to the path selected by that SETUP, the status bit is set again and STALL is released.
- R9: `sts_o` is set on every stage change except the clear-driven return from error to idle. It stays set until `sts_clr_i` is pulsed, and a set in the same cycle wins.
- R10: `irq_o` is high exactly when `sts_o` and `irq_en_i` are both high.
- R11: Tokens and packets in stage 3'b000 leave the stage and status unchanged. Reset gives stage 3'b000, status 0 and `pid_ctl_o` 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_done_i | input | 1 | SETUP packet received and acknowledged |
| setup_dir_i | input | 1 | Request direction, 1 = device-to-host |
| setup_len_i | input | LEN_W | Request length field |
| tok_in_i | input | 1 | IN token on endpoint 0 |
| tok_out_i | input | 1 | OUT token on endpoint 0 |
| tok_ping_i | input | 1 | PING token on endpoint 0 |
| pkt_rx_i | input | 1 | Data packet received on endpoint 0 |
| pkt_data1_i | input | 1 | Data PID of received packet, 1 = DATA1 |
| ack_tx_i | input | 1 | Device sent ACK |
| ack_rx_i | input | 1 | Host returned ACK |
| irq_en_i | input | 1 | Stage interrupt enable |
| sts_clr_i | input | 1 | Software write of 0 to the status bit |
| stage_o | output | 3 | Current stage code |
| sts_o | output | 1 | Stage-change status |
| irq_o | output | 1 | Stage-change interrupt |
| pid_ctl_o | output | 2 | Endpoint-0 response control, 2'b10 = STALL |

## Verification
The hardest situation to reach is a new SETUP that lands while the error code is held. The block must keep the code, suppress the interrupt and remember which path the SETUP chose, then release that path on the clear. The stimulus first provokes an error with an early PING in a read. It then sends a host-to-device SETUP without clearing, and only afterwards pulses the clear. The expected result is the write data stage with the status set again and STALL dropped.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'b000,
    ST_RD_DATA = 3'b001,
    ST_RD_STAT = 3'b010,
    ST_WR_DATA = 3'b011,
    ST_WR_STAT = 3'b100,
    ST_ND_STAT = 3'b101,
    ST_SEQ_ERR = 3'b110
  } stage_e;

  localparam logic [1:0] PID_BUF   = 2'b01;
  localparam logic [1:0] PID_STALL = 2'b10;

  function automatic stage_e path_stage(input logic dir_in, input logic len_zero);
    if (len_zero)    return ST_ND_STAT;
    else if (dir_in) return ST_RD_DATA;
    else             return ST_WR_DATA;
  endfunction
endpackage

// File: rtl/cst_seq_walk.sv
module cst_seq_walk
  import cst_pkg::*;
(
  input  stage_e stage_i,
  input  logic   xfer_i,
  input  logic   pkt_i,
  input  logic   tok_in_i,
  input  logic   tok_out_i,
  input  logic   tok_ping_i,
  input  logic   pkt_rx_i,
  input  logic   pkt_data1_i,
  input  logic   ack_tx_i,
  input  logic   ack_rx_i,
  output stage_e stage_o,
  output logic   xfer_o,
  output logic   pkt_o,
  output logic   err_o
);
  logic out_like;
  assign out_like = tok_out_i | tok_ping_i;

  always_comb begin
    stage_o = stage_i;
    xfer_o  = xfer_i;
    pkt_o   = pkt_i;
    err_o   = 1'b0;
    unique case (stage_i)
      ST_RD_DATA: begin
        if (ack_rx_i) xfer_o = 1'b1;
        if (out_like) begin
          if (xfer_i) stage_o = ST_RD_STAT;
          else        err_o   = 1'b1;
        end
      end
      ST_RD_STAT: begin
        if (tok_in_i) err_o = 1'b1;
        else if (pkt_rx_i) begin
          if (pkt_data1_i) stage_o = ST_IDLE;
          else             err_o   = 1'b1;
        end
      end
      ST_WR_DATA: begin
        if (pkt_rx_i) begin
          pkt_o = 1'b1;
          if (!pkt_i && !pkt_data1_i) err_o = 1'b1;
        end
        if (ack_tx_i) xfer_o = 1'b1;
        if (tok_in_i) begin
          if (xfer_i) stage_o = ST_WR_STAT;
          else        err_o   = 1'b1;
        end
      end
      ST_WR_STAT, ST_ND_STAT: begin
        if (out_like)      err_o   = 1'b1;
        else if (ack_rx_i) stage_o = ST_IDLE;
      end
      default: ;
    endcase
    if (err_o) stage_o = ST_SEQ_ERR;
  end
endmodule

// File: rtl/cst_pend.sv
module cst_pend
  import cst_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   err_held_i,
  input  logic   setup_done_i,
  input  logic   clr_i,
  input  stage_e path_i,
  output logic   pend_o,
  output stage_e pend_stage_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o       <= 1'b0;
      pend_stage_o <= ST_IDLE;
    end else if (err_held_i && clr_i) begin
      pend_o <= 1'b0;
    end else if (err_held_i && setup_done_i) begin
      pend_o       <= 1'b1;
      pend_stage_o <= path_i;
    end
  end
endmodule

// File: rtl/cst_status.sv
module cst_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sts_o <= 1'b0;
    else if (set_i) sts_o <= 1'b1;
    else if (clr_i) sts_o <= 1'b0;
  end
endmodule

// File: rtl/ctrl_stage_tracker.sv
module ctrl_stage_tracker
  import cst_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_done_i,
  input  logic             setup_dir_i,
  input  logic [LEN_W-1:0] setup_len_i,
  input  logic             tok_in_i,
  input  logic             tok_out_i,
  input  logic             tok_ping_i,
  input  logic             pkt_rx_i,
  input  logic             pkt_data1_i,
  input  logic             ack_tx_i,
  input  logic             ack_rx_i,
  input  logic             irq_en_i,
  input  logic             sts_clr_i,
  output logic [2:0]       stage_o,
  output logic             sts_o,
  output logic             irq_o,
  output logic [1:0]       pid_ctl_o
);
  stage_e stage_q, stage_d, walk_stage, path, pend_stage, rel_stage;
  logic   xfer_q, xfer_d, pkt_q, pkt_d;
  logic   walk_xfer, walk_pkt, walk_err;
  logic   err_held, setup_go, rel, drop, sts_set, stall_q, pend;

  assign err_held  = (stage_q == ST_SEQ_ERR);
  assign path      = path_stage(setup_dir_i, setup_len_i == '0);
  assign setup_go  = setup_done_i && !err_held;
  assign rel       = sts_clr_i && err_held && (pend || setup_done_i);
  assign drop      = sts_clr_i && err_held && !rel;
  // a setup in the clearing cycle itself takes precedence over the stored one
  assign rel_stage = setup_done_i ? path : pend_stage;

  cst_seq_walk u_walk (
    .stage_i     (stage_q),
    .xfer_i      (xfer_q),
    .pkt_i       (pkt_q),
    .tok_in_i    (tok_in_i),
    .tok_out_i   (tok_out_i),
    .tok_ping_i  (tok_ping_i),
    .pkt_rx_i    (pkt_rx_i),
    .pkt_data1_i (pkt_data1_i),
    .ack_tx_i    (ack_tx_i),
    .ack_rx_i    (ack_rx_i),
    .stage_o     (walk_stage),
    .xfer_o      (walk_xfer),
    .pkt_o       (walk_pkt),
    .err_o       (walk_err)
  );

  cst_pend u_pend (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .err_held_i   (err_held),
    .setup_done_i (setup_done_i),
    .clr_i        (sts_clr_i),
    .path_i       (path),
    .pend_o       (pend),
    .pend_stage_o (pend_stage)
  );

  always_comb begin
    stage_d = walk_stage;
    xfer_d  = walk_xfer;
    pkt_d   = walk_pkt;
    sts_set = (walk_stage != stage_q);
    if (rel) begin
      stage_d = rel_stage;
      xfer_d  = 1'b0;
      pkt_d   = 1'b0;
      sts_set = 1'b1;
    end else if (drop) begin
      stage_d = ST_IDLE;
      sts_set = 1'b0;
    end else if (setup_go) begin
      stage_d = path;
      xfer_d  = 1'b0;
      pkt_d   = 1'b0;
      sts_set = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE;
      xfer_q  <= 1'b0;
      pkt_q   <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      xfer_q  <= xfer_d;
      pkt_q   <= pkt_d;
      if (rel || setup_go)                 stall_q <= 1'b0;
      else if (walk_err && !err_held)      stall_q <= 1'b1;
    end
  end

  cst_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sts_set),
    .clr_i  (sts_clr_i),
    .sts_o  (sts_o)
  );

  assign stage_o   = stage_q;
  assign irq_o     = sts_o && irq_en_i;
  assign pid_ctl_o = stall_q ? PID_STALL : PID_BUF;
endmodule

// File: rtl/ctrl_stage_tracker_chk.sv
module ctrl_stage_tracker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       setup_done_i,
  input logic       sts_clr_i,
  input logic       irq_en_i,
  input logic [2:0] stage_o,
  input logic       sts_o,
  input logic       irq_o,
  input logic [1:0] pid_ctl_o
);
  p_err_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == 3'b110) |-> (pid_ctl_o == 2'b10));

  p_err_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == 3'b110 && !sts_clr_i) |=> (stage_o == 3'b110));

  p_setup_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_done_i && stage_o != 3'b110)
      |=> (stage_o != 3'b000 && stage_o != 3'b110 && pid_ctl_o == 2'b01));

  p_held_setup_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == 3'b110 && setup_done_i && !sts_clr_i) |=> (stage_o == 3'b110));

  p_sts_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o && !sts_clr_i) |=> sts_o);

  p_irq_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && sts_o));

  p_code_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o != 3'b111);
endmodule

bind ctrl_stage_tracker ctrl_stage_tracker_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .setup_done_i (setup_done_i),
  .sts_clr_i    (sts_clr_i),
  .irq_en_i     (irq_en_i),
  .stage_o      (stage_o),
  .sts_o        (sts_o),
  .irq_o        (irq_o),
  .pid_ctl_o    (pid_ctl_o)
);

// File: tb/ctrl_stage_tracker_tb.sv
module ctrl_stage_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  localparam logic [3:0] E_NONE = 4'd0, E_SETUP = 4'd1, E_IN = 4'd2, E_OUT = 4'd3,
                         E_PING = 4'd4, E_ACKRX = 4'd5, E_ACKTX = 4'd6, E_PKT0 = 4'd7,
                         E_PKT1 = 4'd8, E_CLR = 4'd9;
  localparam int NV = 54;
  // {event, dir, len_zero, exp_stage, exp_sts, exp_pid}
  localparam logic [11:0] VEC [NV] = '{
    {E_SETUP,1'b1,1'b0,3'b001,1'b1,2'b01},  // R1 read
    {E_CLR  ,1'b0,1'b0,3'b001,1'b0,2'b01},  // R9
    {E_IN   ,1'b0,1'b0,3'b001,1'b0,2'b01},  // R2
    {E_ACKRX,1'b0,1'b0,3'b001,1'b0,2'b01},
    {E_OUT  ,1'b0,1'b0,3'b010,1'b1,2'b01},  // R2
    {E_CLR  ,1'b0,1'b0,3'b010,1'b0,2'b01},
    {E_PKT1 ,1'b0,1'b0,3'b000,1'b1,2'b01},  // R3 any length
    {E_CLR  ,1'b0,1'b0,3'b000,1'b0,2'b01},
    {E_IN   ,1'b0,1'b0,3'b000,1'b0,2'b01},  // R11
    {E_SETUP,1'b1,1'b0,3'b001,1'b1,2'b01},
    {E_PING ,1'b0,1'b0,3'b110,1'b1,2'b10},  // R2 early ping
    {E_SETUP,1'b0,1'b0,3'b110,1'b1,2'b10},  // R8 held
    {E_CLR  ,1'b0,1'b0,3'b011,1'b1,2'b01},  // R8 release
    {E_CLR  ,1'b0,1'b0,3'b011,1'b0,2'b01},
    {E_PKT1 ,1'b0,1'b0,3'b011,1'b0,2'b01},  // R4
    {E_ACKTX,1'b0,1'b0,3'b011,1'b0,2'b01},
    {E_PKT1 ,1'b0,1'b0,3'b011,1'b0,2'b01},  // R4 beyond length
    {E_ACKTX,1'b0,1'b0,3'b011,1'b0,2'b01},
    {E_IN   ,1'b0,1'b0,3'b100,1'b1,2'b01},  // R4
    {E_ACKRX,1'b0,1'b0,3'b000,1'b1,2'b01},  // R5
    {E_CLR  ,1'b0,1'b0,3'b000,1'b0,2'b01},
    {E_SETUP,1'b0,1'b0,3'b011,1'b1,2'b01},
    {E_PKT0 ,1'b0,1'b0,3'b110,1'b1,2'b10},  // R4 first DATA0
    {E_CLR  ,1'b0,1'b0,3'b000,1'b0,2'b10},  // R7, R6 stall kept
    {E_IN   ,1'b0,1'b0,3'b000,1'b0,2'b10},  // R11
    {E_SETUP,1'b0,1'b0,3'b011,1'b1,2'b01},  // R6 cleared
    {E_PKT1 ,1'b0,1'b0,3'b011,1'b1,2'b01},
    {E_IN   ,1'b0,1'b0,3'b110,1'b1,2'b10},  // R4 IN before ack
    {E_CLR  ,1'b0,1'b0,3'b000,1'b0,2'b10},
    {E_SETUP,1'b0,1'b1,3'b101,1'b1,2'b01},  // R1 no-data
    {E_CLR  ,1'b0,1'b0,3'b101,1'b0,2'b01},
    {E_OUT  ,1'b0,1'b0,3'b110,1'b1,2'b10},  // R5
    {E_CLR  ,1'b0,1'b0,3'b000,1'b0,2'b10},
    {E_SETUP,1'b1,1'b1,3'b101,1'b1,2'b01},  // R1 zero length
    {E_ACKRX,1'b0,1'b0,3'b000,1'b1,2'b01},  // R5
    {E_SETUP,1'b1,1'b0,3'b001,1'b1,2'b01},
    {E_ACKRX,1'b0,1'b0,3'b001,1'b1,2'b01},
    {E_OUT  ,1'b0,1'b0,3'b010,1'b1,2'b01},
    {E_IN   ,1'b0,1'b0,3'b110,1'b1,2'b10},  // R3 IN in status
    {E_CLR  ,1'b0,1'b0,3'b000,1'b0,2'b10},
    {E_SETUP,1'b1,1'b0,3'b001,1'b1,2'b01},
    {E_ACKRX,1'b0,1'b0,3'b001,1'b1,2'b01},
    {E_PING ,1'b0,1'b0,3'b010,1'b1,2'b01},
    {E_PKT0 ,1'b0,1'b0,3'b110,1'b1,2'b10},  // R3 DATA0
    {E_CLR  ,1'b0,1'b0,3'b000,1'b0,2'b10},
    {E_SETUP,1'b0,1'b0,3'b011,1'b1,2'b01},
    {E_ACKTX,1'b0,1'b0,3'b011,1'b1,2'b01},
    {E_IN   ,1'b0,1'b0,3'b100,1'b1,2'b01},
    {E_PING ,1'b0,1'b0,3'b110,1'b1,2'b10},  // R5
    {E_CLR  ,1'b0,1'b0,3'b000,1'b0,2'b10},
    {E_SETUP,1'b1,1'b0,3'b001,1'b1,2'b01},
    {E_SETUP,1'b0,1'b0,3'b011,1'b1,2'b01},  // R1 restart mid-transfer
    {E_CLR  ,1'b0,1'b0,3'b011,1'b0,2'b01},
    {E_SETUP,1'b0,1'b1,3'b101,1'b1,2'b01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic setup_done = 0, setup_dir = 0, tok_in = 0, tok_out = 0, tok_ping = 0;
  logic pkt_rx = 0, pkt_d1 = 0, ack_tx = 0, ack_rx = 0, irq_en = 0, sts_clr = 0;
  logic [LEN_W-1:0] setup_len = '0;
  logic [2:0] stage;
  logic sts, irq;
  logic [1:0] pid;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_stage_tracker #(.LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .setup_done_i(setup_done), .setup_dir_i(setup_dir),
    .setup_len_i(setup_len), .tok_in_i(tok_in), .tok_out_i(tok_out), .tok_ping_i(tok_ping),
    .pkt_rx_i(pkt_rx), .pkt_data1_i(pkt_d1), .ack_tx_i(ack_tx), .ack_rx_i(ack_rx),
    .irq_en_i(irq_en), .sts_clr_i(sts_clr), .stage_o(stage), .sts_o(sts), .irq_o(irq),
    .pid_ctl_o(pid)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ev, input logic dir, input logic lz);
    setup_done = (ev == E_SETUP); setup_dir = dir; setup_len = lz ? '0 : LEN_W'(8);
    tok_in = (ev == E_IN); tok_out = (ev == E_OUT); tok_ping = (ev == E_PING);
    pkt_rx = (ev == E_PKT0) || (ev == E_PKT1); pkt_d1 = (ev == E_PKT1);
    ack_tx = (ev == E_ACKTX); ack_rx = (ev == E_ACKRX); sts_clr = (ev == E_CLR);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset stage", {1'b0, stage}, 4'h0);
    chk("R11 reset sts", {3'b0, sts}, 4'h0);
    chk("R11 reset pid", {2'b0, pid}, 4'h1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      irq_en = (i % 3 != 0);
      drive(v[11:8], v[7], v[6]);
      @(negedge clk);
      chk("R1-path stage", {1'b0, stage}, {1'b0, v[5:3]});
      chk("R9 status", {3'b0, sts}, {3'b0, v[2]});
      chk("R6 pid ctl", {2'b0, pid}, {2'b0, v[1:0]});
      chk("R10 irq", {3'b0, irq}, {3'b0, v[2] & irq_en});
    end
    drive(E_NONE, 1'b0, 1'b0);
    // R8: setup and clear in the same cycle while an error is held
    drive(E_PING, 1'b0, 1'b0); @(negedge clk);
    drive(E_NONE, 1'b0, 1'b0); @(negedge clk);
    chk("R5 nd ping err", {1'b0, stage}, 4'h6);
    setup_done = 1'b1; setup_dir = 1'b1; setup_len = LEN_W'(4); sts_clr = 1'b1;
    @(negedge clk);
    drive(E_NONE, 1'b0, 1'b0);
    chk("R8 same-cycle release stage", {1'b0, stage}, 4'h1);
    chk("R8 same-cycle release sts", {3'b0, sts}, 4'h1);
    chk("R6 stall released", {2'b0, pid}, 4'h1);
    // R11 reset mid transfer
    rst_n = 1'b0; @(negedge clk);
    chk("R11 reset stage again", {1'b0, stage}, 4'h0);
    chk("R11 reset sts again", {3'b0, sts}, 4'h0);
    rst_n = 1'b1; @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule